// File: doc/BRIEF.md
# Framebuffer Fill DMA Engine

This block copies one frame of picture words out of shared memory into a frame FIFO, one word per memory cycle, as fast as the memory allows. It does not follow horizontal or vertical sync. A separate timing chain drains the FIFOs at the display rate. Two FIFOs are used, and the engine fills one while the other is drained. Because the role of the two swaps at every frame, the display output runs exactly one frame behind the fill.

The CPU always owns shared memory when it asks for it, and the fetch side absorbs every wait. In any cycle where the CPU requests memory, the engine issues no read. Its address counter holds, so the walk resumes at the same word once the CPU lets go. Memory returns read data one cycle after a read. That data goes straight to the write port of the FIFO being filled, and the write strobe fires only in cycles that follow a granted read.

A one-cycle frame-start pulse does four things: it swaps the target FIFO, pulses that FIFO's write-pointer reset, rewinds the address to the framebuffer base and starts the walk. After the last active word has been written, the engine drops busy and raises done. If a frame start arrives while a fill is still running, the engine sets a sticky overrun flag and begins the new fill anyway.

Top module: `fb_fill_dma`

## Requirements
- R1: While filling, reads go to BASE_ADDR, BASE_ADDR+1, ... BASE_ADDR+WORDS-1 in strict order, each address read exactly once per frame. After the last one, no further reads are issued until the next frame start.
- R2: In any cycle with `cpu_req_i` high, `mem_rd_o` is low.
- R3: The address presented after a stall equals the address that was pending when the stall began; stalled cycles skip no word.
- R4: For each cycle with `mem_rd_o` high, exactly one FIFO write occurs in the following cycle. It goes to the FIFO indexed by `fill_sel_o` (bit 0 = FIFO 0, bit 1 = FIFO 1) and carries `mem_rdata_i` as `fifo_wdata_o`. No write occurs in any other cycle.
- R5: `fill_sel_o` is 1 after reset and inverts on every frame start, so the first frame fills FIFO 0.
- R6: In the cycle after a frame start, `fifo_wrst_o` has exactly the bit of the newly selected FIFO set. It is zero in every other cycle.
- R7: `busy_o` rises in the cycle after a frame start. In the cycle after the last of WORDS writes, `busy_o` falls and `done_o` rises. `done_o` stays high until the cycle after the next frame start.
- R8: A frame start while `busy_o` is high sets `overrun_o`, which stays set until reset. The new fill starts normally, from the base address.
- R9: During and after reset, with no frame start: no reads, no writes, no write-pointer reset, `busy_o`, `done_o` and `overrun_o` low, `fill_sel_o` high.
- R10: No read is issued in a cycle where `frame_start_i` is high, nor while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | One-cycle pulse starting a new frame fill |
| cpu_req_i | input | 1 | CPU is using shared memory this cycle |
| mem_rd_o | output | 1 | Engine read of shared memory this cycle |
| mem_addr_o | output | ADDR_W | Read address |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after a read |
| fifo_wr_o | output | 2 | Write strobe per FIFO |
| fifo_wdata_o | output | DATA_W | Data for the FIFO write port |
| fifo_wrst_o | output | 2 | Write-pointer reset per FIFO |
| fill_sel_o | output | 1 | FIFO currently being filled |
| busy_o | output | 1 | Fill in progress |
| done_o | output | 1 | Current frame fully written |
| overrun_o | output | 1 | Sticky: frame start arrived during a fill |

## Verification
The assertions assume that `frame_start_i` is a single-cycle pulse and that shared memory presents its data exactly one cycle after `mem_rd_o`. The CPU request line may follow any pattern at all. The bench memory model registers its output on each granted read, so the one-cycle latency always holds. Frame starts are only ever driven for one cycle. CPU activity comes from an LFSR, together with long held bursts and bursts that overlap frame starts, which covers stalls at every position in the walk. One frame start is deliberately placed mid-fill to exercise the overrun path.

// File: rtl/fb_fill_pkg.sv
package fb_fill_pkg;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_mode_e;

    typedef struct packed {
        fill_mode_e mode;
        logic       done;
    } fill_ctl_t;

    typedef struct packed {
        logic       sel;
        logic [1:0] wrst;
        logic       ovr;
    } sel_state_t;

endpackage

// File: rtl/fb_addr_gen.sv
module fb_addr_gen #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int                WORDS     = 48,
    parameter int                CNT_W     = $clog2(WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              grant_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              all_issued_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ag_state_t;

    ag_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            s_d.cnt = '0;
        end else if (grant_i && !all_issued_o) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign all_issued_o = (s_q.cnt == CNT_W'(WORDS));
    assign addr_o       = BASE_ADDR + ADDR_W'(s_q.cnt);

    // R3: the address holds when no read is granted
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !grant_i) |=> $stable(addr_o));

    // R1: the walk never runs past the active word count
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(WORDS));

endmodule

// File: rtl/fb_wr_track.sv
module fb_wr_track #(
    parameter int WORDS = 48,
    parameter int CNT_W = $clog2(WORDS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic rd_issued_i,
    output logic wr_en_o,
    output logic last_wr_o
);

    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] wcnt;
    } wt_state_t;

    wt_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pend = rd_issued_i;
        if (restart_i) begin
            s_d.wcnt = '0;
        end else if (s_q.pend) begin
            s_d.wcnt = s_q.wcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_en_o   = s_q.pend;
    assign last_wr_o = s_q.pend && (s_q.wcnt == CNT_W'(WORDS - 1));

    // R7: writes within a frame never exceed the active word count
    p_wcnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wcnt <= CNT_W'(WORDS));

endmodule

// File: rtl/fb_fifo_sel.sv
module fb_fifo_sel
    import fb_fill_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start_i,
    input  logic       busy_i,
    output logic       sel_o,
    output logic [1:0] wrst_o,
    output logic       overrun_o
);

    sel_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.wrst = 2'b00;
        if (frame_start_i) begin
            s_d.sel  = ~s_q.sel;
            s_d.wrst = s_q.sel ? 2'b01 : 2'b10;
            s_d.ovr  = s_q.ovr | busy_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sel: 1'b1, wrst: 2'b00, ovr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_o     = s_q.sel;
    assign wrst_o    = s_q.wrst;
    assign overrun_o = s_q.ovr;

    // R5: every frame start swaps the target FIFO
    p_sel_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (sel_o != $past(sel_o)));

    // R6: reset pulse touches at most the FIFO now being filled
    p_wrst_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wrst_o) && ((wrst_o == 2'b00) || wrst_o[sel_o]));

    // R8: overrun is sticky
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

endmodule

// File: rtl/fb_fill_dma.sv
module fb_fill_dma
    import fb_fill_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400,
    parameter int                WORDS     = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              cpu_req_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [1:0]        fifo_wr_o,
    output logic [DATA_W-1:0] fifo_wdata_o,
    output logic [1:0]        fifo_wrst_o,
    output logic              fill_sel_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              overrun_o
);

    localparam int CNT_W = $clog2(WORDS + 1);

    fill_ctl_t c_d, c_q;
    logic      all_issued;
    logic      wr_en;
    logic      last_wr;

    always_comb begin
        c_d = c_q;
        if (frame_start_i) begin
            c_d.mode = FILL_RUN;
            c_d.done = 1'b0;
        end else if (c_q.mode == FILL_RUN && last_wr) begin
            c_d.mode = FILL_IDLE;
            c_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{mode: FILL_IDLE, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o   = (c_q.mode == FILL_RUN);
    assign done_o   = c_q.done;
    assign mem_rd_o = busy_o && !cpu_req_i && !frame_start_i && !all_issued;

    fb_addr_gen #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .WORDS    (WORDS),
        .CNT_W    (CNT_W)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (frame_start_i),
        .grant_i     (mem_rd_o),
        .addr_o      (mem_addr_o),
        .all_issued_o(all_issued)
    );

    fb_wr_track #(
        .WORDS(WORDS),
        .CNT_W(CNT_W)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (frame_start_i),
        .rd_issued_i(mem_rd_o),
        .wr_en_o    (wr_en),
        .last_wr_o  (last_wr)
    );

    fb_fifo_sel u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start_i),
        .busy_i       (busy_o),
        .sel_o        (fill_sel_o),
        .wrst_o       (fifo_wrst_o),
        .overrun_o    (overrun_o)
    );

    for (genvar k = 0; k < 2; k++) begin : g_fifo_wr
        assign fifo_wr_o[k] = wr_en && (fill_sel_o == 1'(k));
    end

    assign fifo_wdata_o = mem_rdata_i;

    // R2: the CPU always wins shared memory
    p_cpu_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_i |-> !mem_rd_o);

    // R4: a FIFO write only follows a granted read
    p_wr_follows_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_o != 2'b00) |-> $past(mem_rd_o));

    // R4: a granted read always produces a write next cycle
    p_rd_gives_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> $onehot(fifo_wr_o));

    // R10: no read in the frame-start cycle
    p_no_read_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |-> !mem_rd_o);

    // R7: done and busy are exclusive, and done clears after a frame start
    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    p_done_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (!done_o && busy_o));

endmodule

// File: tb/fb_fill_dma_bench.sv
module fb_fill_dma_bench;

    localparam int          ADDR_W = 16;
    localparam int          DATA_W = 16;
    localparam logic [15:0] BASE   = 16'h0400;
    localparam int          WORDS  = 48;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              cpu_req = 1'b0;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [1:0]        fifo_wr;
    logic [DATA_W-1:0] fifo_wdata;
    logic [1:0]        fifo_wrst;
    logic              fill_sel;
    logic              busy;
    logic              done;
    logic              overrun;

    always #4 clk = ~clk;

    fb_fill_dma #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE), .WORDS(WORDS)
    ) u_fb_fill_dma (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .cpu_req_i(cpu_req),
        .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .fifo_wr_o(fifo_wr), .fifo_wdata_o(fifo_wdata), .fifo_wrst_o(fifo_wrst),
        .fill_sel_o(fill_sel), .busy_o(busy), .done_o(done), .overrun_o(overrun)
    );

    function automatic logic [DATA_W-1:0] word_at(input int a);
        return DATA_W'(a * 37 + 11);
    endfunction

    // shared memory: data one cycle after a read
    always @(posedge clk) if (mem_rd) mem_rdata <= word_at(int'(mem_addr));

    int n_run  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    bit m_busy, m_done, m_sel, m_ovr, m_pend;
    int m_issued, m_written, m_pend_addr, m_wrst;
    bit stall_prev;

    always @(posedge clk) begin
        bit rd;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_sel = 1; m_ovr = 0; m_pend = 0;
            m_issued = 0; m_written = 0; m_pend_addr = 0; m_wrst = -1;
            stall_prev = 0;
        end else begin
            rd = m_busy && !cpu_req && !frame_start && (m_issued < WORDS);
            stall_prev = m_busy && cpu_req;
            if (frame_start) begin
                m_ovr = m_ovr | m_busy;
                m_busy = 1; m_done = 0; m_sel = ~m_sel; m_wrst = m_sel;
                m_issued = 0; m_written = 0;
            end else begin
                m_wrst = -1;
                if (m_pend) m_written++;
                if (m_busy && m_written == WORDS) begin
                    m_busy = 0; m_done = 1;
                end
            end
            m_pend_addr = int'(BASE) + m_issued;
            if (rd) m_issued++;
            m_pend = rd;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        bit    exp_rd;
        string t;
        #1;
        exp_rd = m_busy && !cpu_req && !frame_start && (m_issued < WORDS);
        if (!rst_n) t = "R9";
        else if (frame_start || !m_busy) t = "R10";
        else if (cpu_req) t = "R2";
        else t = "R1";
        chk(mem_rd == exp_rd, t, "mem_rd", mem_rd, exp_rd);
        if (exp_rd && mem_rd)
            chk(mem_addr == ADDR_W'(int'(BASE) + m_issued), stall_prev ? "R3" : "R1",
                "mem_addr", mem_addr, int'(BASE) + m_issued);
        chk(fifo_wr == (m_pend ? (2'b01 << m_sel) : 2'b00), rst_n ? "R4" : "R9",
            "fifo_wr", fifo_wr, m_pend ? (2'b01 << m_sel) : 2'b00);
        if (m_pend)
            chk(fifo_wdata == word_at(m_pend_addr), "R4", "fifo_wdata",
                fifo_wdata, word_at(m_pend_addr));
        chk(fifo_wrst == ((m_wrst >= 0) ? (2'b01 << m_wrst) : 2'b00), rst_n ? "R6" : "R9",
            "fifo_wrst", fifo_wrst, (m_wrst >= 0) ? (2'b01 << m_wrst) : 2'b00);
        chk(fill_sel == m_sel, rst_n ? "R5" : "R9", "fill_sel", fill_sel, m_sel);
        chk(busy == m_busy, rst_n ? "R7" : "R9", "busy", busy, m_busy);
        chk(done == m_done, rst_n ? "R7" : "R9", "done", done, m_done);
        chk(overrun == m_ovr, rst_n ? "R8" : "R9", "overrun", overrun, m_ovr);
    end

    task automatic cycle(input bit fs, input bit cpu);
        @(negedge clk);
        frame_start = fs;
        cpu_req     = cpu;
    endtask

    int lfsr = 32'h1ACE;

    function automatic bit next_cpu();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h0000_B400 : 0);
        return (lfsr % 3) == 0;
    endfunction

    task automatic run_to_done(input int mode, input string tag);
        bit hit = 0;
        for (int i = 0; i < 2000; i++) begin
            if (mode == 0) cycle(0, 0);
            else cycle(0, next_cpu());
            #2;
            if (done) begin
                hit = 1;
                break;
            end
        end
        chk(hit, tag, "fill completes", hit, 1);
    endtask

    initial begin
        #150000;
        chk(0, "R7", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) cycle(0, 0);
        @(negedge clk); rst_n = 1'b1;
        // R10: idle engine ignores CPU activity and reads nothing
        for (int i = 0; i < 6; i++) cycle(0, i[0]);
        // R1 R4 R5 R6: clean frame into FIFO 0
        cycle(1, 0);
        run_to_done(0, "R7");
        repeat (3) cycle(0, 0);
        // R2 R3: LFSR stalls into FIFO 1
        cycle(1, 0);
        run_to_done(1, "R3");
        // R10: frame start while CPU is also requesting
        cycle(1, 1);
        for (int i = 0; i < 20; i++) cycle(0, 1);
        run_to_done(0, "R2");
        // R8: frame start mid-fill
        cycle(1, 0);
        repeat (10) cycle(0, 0);
        cycle(1, 0);
        run_to_done(1, "R8");
        // R8: overrun stays set across a clean frame
        cycle(1, 0);
        run_to_done(0, "R8");
        // frame start on the final write cycle
        cycle(1, 0);
        for (int i = 0; i < WORDS; i++) cycle(0, 0);
        cycle(1, 0);
        run_to_done(1, "R7");
        repeat (4) cycle(0, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule